// File: doc/BRIEF.md
# Quick DMA Trigger-Word Channel Mapper

This block sits on a 32-bit register bus in front of a DMA address engine. It watches CPU writes into a window of parameter slots. Each slot is 32 bytes long and holds eight 32-bit words. Each of eight quick channels is pointed at one slot and at one word inside that slot. A write to that word starts a transfer on the channel. No separate start bit is needed: software fills the slot and writes the chosen word last, and that last write launches the work.

A launched channel sends a one-cycle request to the address engine. The request carries the channel as a bit of a vector and the slot number as a field. The channel then stays outstanding until the engine returns a completion for it. A trigger that arrives while the channel is outstanding is not forwarded; it is recorded as a missed event instead. Each completion also carries a 6-bit code, which sets one bit in a 64-bit pending map. Software clears pending bits by writing ones to them. The block has write-one-to-set and write-one-to-clear enable registers, and write-one-to-clear registers for the missed and outstanding flags.

Top module: `qdma_trig_mapper`

## Requirements
- R1: After a synchronous active-low reset, these all read zero: every map register, enable (0x108C), outstanding (0x1090), missed (0x310), pending low (0x1068) and pending high (0x106C). No request is raised.
- R2: The map register of channel n is at 0x200 + 4n. Its slot number is in bits 13:5 and its word index in bits 4:2. These fields read back as written, and all other bits read zero.
- R3: Writing a 1 to bit n of 0x108C enables channel n. Writing a 1 to bit n of 0x1088 disables it. Zero bits in either write leave the enable unchanged. The enable mask reads back at 0x108C.
- R4: Channel n must be enabled and not outstanding. A write to byte address 0x4000 + 32·slot + 4·word, matching the map of channel n, then raises req_valid[n] for exactly one cycle. The pulse begins in the second cycle after the write cycle, and req_slot equals the slot. The same event sets bit n of 0x1090. All channels that match one write are requested together.
- R5: No request is raised for a write to a different word of the mapped slot, or for a write that matches a disabled channel.
- R6: A matching trigger on an enabled channel whose bit in 0x1090 is set raises no request. It sets bit n of 0x310 instead.
- R7: A completion (done_valid with done_chan = n) clears bit n of 0x1090. A code c below 32 sets bit c of 0x1068. A code of 32 to 63 sets bit c−32 of 0x106C.
- R8: Writing ones to 0x1070 or 0x1074 clears the matching bits of 0x1068 or 0x106C. When a completion sets a bit in the same cycle as a write clears it, the bit ends up set.
- R9: Writing a 1 to bit n of 0x314 clears missed bit n. Writing a 1 to bit n of 0x1094 clears outstanding bit n.
- R10: A write that clears enable bit n (0x1088) or missed bit n (0x314) may come in the cycle right after a trigger write. It then overrides that trigger for channel n: no request is raised, no missed bit is set, and the outstanding bit stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 16 | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| done_valid | input | 1 | Completion strobe from the transfer engine |
| done_chan | input | 3 | Channel whose transfer completed |
| done_code | input | 6 | Completion code selecting the pending bit |
| req_valid | output | 8 | One-cycle request, one bit per channel |
| req_slot | output | 9 | Parameter slot of the request |

## Verification
The hardest cases are the override cases. There is only one write port, so an enable-clear or missed-clear write can never share a cycle with a trigger write. The bench instead issues two back-to-back writes: the trigger first and the clear second. The clear then lands in the cycle in which the latched trigger is evaluated. The missed-event path needs the channel to be outstanding already, so the bench leaves a completion unanswered and then writes the trigger word again. The pending set-versus-clear collision is reached by driving a completion and a pending-clear write on the same clock edge.

// File: rtl/qdma_pkg.sv
// Shared constants for the quick DMA trigger-word channel mapper.
// Assumes byte addressing on a 32-bit register bus.
package qdma_pkg;
    localparam int MAP_BASE     = 32'h0200;
    localparam int MISS_STAT    = 32'h0310;
    localparam int MISS_CLR     = 32'h0314;
    localparam int PEND_LO      = 32'h1068;
    localparam int PEND_HI      = 32'h106C;
    localparam int PCLR_LO      = 32'h1070;
    localparam int PCLR_HI      = 32'h1074;
    localparam int EN_CLR       = 32'h1088;
    localparam int EN_SET       = 32'h108C;
    localparam int SEC_STAT     = 32'h1090;
    localparam int SEC_CLR      = 32'h1094;
    localparam int SLOT_BASE    = 32'h4000;
    localparam int MAP_WORD_LSB = 2;
    localparam int MAP_SLOT_LSB = 5;
endpackage

// File: rtl/qdma_map_regs.sv
// Per-channel map registers (slot number, trigger word index) plus the
// comparator that flags which channels a slot-window write hits.
// Assumes the top has already decoded the slot window and map addresses.
module qdma_map_regs #(
    parameter int NCH    = 8,
    parameter int SLOT_W = 9,
    parameter int WORD_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NCH-1:0]                 map_we,
    input  logic [SLOT_W-1:0]              wr_slot,
    input  logic [WORD_W-1:0]              wr_word,
    input  logic                           slot_wr,
    input  logic [SLOT_W-1:0]              slot_idx,
    input  logic [WORD_W-1:0]              word_idx,
    output logic [NCH-1:0][SLOT_W-1:0]     map_slot,
    output logic [NCH-1:0][WORD_W-1:0]     map_word,
    output logic [NCH-1:0]                 hit_vec
);
    // Store a new slot/word pair for each channel whose map register is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_slot <= '0;
            map_word <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (map_we[i]) begin
                    map_slot[i] <= wr_slot;
                    map_word[i] <= wr_word;
                end
            end
        end
    end

    // One comparator per channel: does this write land on its trigger word?
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign hit_vec[g] = slot_wr && (slot_idx == map_slot[g])
                                    && (word_idx == map_word[g]);
    end
endmodule

// File: rtl/qdma_evt_ctrl.sv
// Channel event control: enable, outstanding (secondary) and missed flags.
// A trigger hit is latched for one cycle and then evaluated, so that a
// clearing write in the following cycle can override it.
// Assumes at most one completion per cycle.
module qdma_evt_ctrl #(
    parameter int NCH    = 8,
    parameter int SLOT_W = 9,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    hit_vec,
    input  logic [SLOT_W-1:0] hit_slot,
    input  logic              en_set_we,
    input  logic              en_clr_we,
    input  logic              miss_clr_we,
    input  logic              sec_clr_we,
    input  logic [NCH-1:0]    wmask,
    input  logic              done_valid,
    input  logic [CH_W-1:0]   done_chan,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    sec_q,
    output logic [NCH-1:0]    miss_q,
    output logic [NCH-1:0]    req_valid,
    output logic [SLOT_W-1:0] req_slot
);
    logic [NCH-1:0]    trig_q;
    logic [SLOT_W-1:0] trig_slot_q;
    logic [NCH-1:0]    en_set_m, en_clr_m, miss_clr_m, sec_clr_m, done_m;
    logic [NCH-1:0]    live, accept, miss_set;

    // Decode the write-one masks and judge the latched trigger.
    always_comb begin
        en_set_m   = en_set_we   ? wmask : '0;
        en_clr_m   = en_clr_we   ? wmask : '0;
        miss_clr_m = miss_clr_we ? wmask : '0;
        sec_clr_m  = sec_clr_we  ? wmask : '0;
        done_m     = done_valid  ? (NCH'(1) << done_chan) : '0;
        live       = trig_q & en_q & ~en_clr_m & ~miss_clr_m;
        accept     = live & ~sec_q;
        miss_set   = live & sec_q;
    end

    // Trigger latch stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q      <= '0;
            trig_slot_q <= '0;
        end else begin
            trig_q      <= hit_vec;
            trig_slot_q <= hit_slot;
        end
    end

    // Flag registers and the registered request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            sec_q     <= '0;
            miss_q    <= '0;
            req_valid <= '0;
            req_slot  <= '0;
        end else begin
            en_q      <= (en_q | en_set_m) & ~en_clr_m;
            sec_q     <= (sec_q & ~sec_clr_m & ~done_m) | accept;
            miss_q    <= (miss_q & ~miss_clr_m) | miss_set;
            req_valid <= accept;
            req_slot  <= trig_slot_q;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R4
        req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[g] |-> $past(en_q[g]));
        // R6
        req_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[g] |-> !$past(sec_q[g]));
        // R6
        miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(miss_q[g]) |-> ($past(sec_q[g]) && $past(trig_q[g])));
        // R4
        sec_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sec_q[g]) |-> req_valid[g]);
        // R10
        enclr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en_clr_we && wmask[g]) |-> !req_valid[g]);
    end
endmodule

// File: rtl/qdma_pend.sv
// Completion-pending map: a completion code sets one bit; software clears
// bits word by word with write-one-to-clear. A set in the same cycle wins.
module qdma_pend #(
    parameter int CODE_W = 6,
    localparam int NPEND = 1 << CODE_W,
    localparam int NW    = NPEND / 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_valid,
    input  logic [CODE_W-1:0] done_code,
    input  logic [NW-1:0]     clr_we,
    input  logic [31:0]       wdata,
    output logic [NPEND-1:0]  pend_q
);
    logic [NPEND-1:0] set_m, clr_m;

    // Build the per-word clear mask.
    for (genvar w = 0; w < NW; w++) begin : g_clr
        assign clr_m[w*32 +: 32] = clr_we[w] ? wdata : '0;
    end

    // Completion code to one-hot set mask.
    always_comb set_m = done_valid ? (NPEND'(1) << done_code) : '0;

    // Pending register update with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_m) | set_m;
    end

    for (genvar k = 0; k < NPEND; k++) begin : g_chk
        // R7
        pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[k]) |-> ($past(done_valid) && $past(done_code) == CODE_W'(k)));
        // R8
        pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_q[k]) |-> ($past(clr_m[k]) &&
                                  !($past(done_valid) && $past(done_code) == CODE_W'(k))));
    end
endmodule

// File: rtl/qdma_trig_mapper.sv
// Top of the quick DMA trigger-word channel mapper: decodes the register
// bus, owns the read multiplexer and ties map, event and pending logic.
// Assumes single-cycle writes, combinational reads, and base addresses
// aligned to the size of their windows.
module qdma_trig_mapper
    import qdma_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int SLOT_W = 9,
    parameter int WORD_W = 3,
    parameter int CODE_W = 6,
    parameter int AW     = 16,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              done_valid,
    input  logic [CH_W-1:0]   done_chan,
    input  logic [CODE_W-1:0] done_code,
    output logic [NCH-1:0]    req_valid,
    output logic [SLOT_W-1:0] req_slot
);
    localparam int SLOT_SH = WORD_W + 2;
    localparam int REG_TOP = SLOT_SH + SLOT_W;
    localparam int MAP_TOP = 2 + CH_W;
    localparam int NPEND   = 1 << CODE_W;

    logic                       aligned, slot_area, slot_wr, map_area;
    logic [CH_W-1:0]            map_idx;
    logic [NCH-1:0]             map_we, hit_vec;
    logic [NCH-1:0][SLOT_W-1:0] map_slot;
    logic [NCH-1:0][WORD_W-1:0] map_word;
    logic [NCH-1:0]             en_q, sec_q, miss_q;
    logic [NPEND-1:0]           pend_q;
    logic                       en_set_we, en_clr_we, miss_clr_we, sec_clr_we;
    logic [1:0]                 pclr_we;

    // Address window and write-strobe decode.
    always_comb begin
        aligned     = (bus_addr[1:0] == 2'b00);
        slot_area   = aligned && (bus_addr[AW-1:REG_TOP] == (AW-REG_TOP)'(SLOT_BASE >> REG_TOP));
        slot_wr     = bus_wr && slot_area;
        map_area    = aligned && (bus_addr[AW-1:MAP_TOP] == (AW-MAP_TOP)'(MAP_BASE >> MAP_TOP));
        map_idx     = bus_addr[2 +: CH_W];
        map_we      = (bus_wr && map_area) ? (NCH'(1) << map_idx) : '0;
        en_set_we   = bus_wr && (bus_addr == AW'(EN_SET));
        en_clr_we   = bus_wr && (bus_addr == AW'(EN_CLR));
        miss_clr_we = bus_wr && (bus_addr == AW'(MISS_CLR));
        sec_clr_we  = bus_wr && (bus_addr == AW'(SEC_CLR));
        pclr_we[0]  = bus_wr && (bus_addr == AW'(PCLR_LO));
        pclr_we[1]  = bus_wr && (bus_addr == AW'(PCLR_HI));
    end

    qdma_map_regs #(.NCH(NCH), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_we   (map_we),
        .wr_slot  (bus_wdata[MAP_SLOT_LSB +: SLOT_W]),
        .wr_word  (bus_wdata[MAP_WORD_LSB +: WORD_W]),
        .slot_wr  (slot_wr),
        .slot_idx (bus_addr[SLOT_SH +: SLOT_W]),
        .word_idx (bus_addr[2 +: WORD_W]),
        .map_slot (map_slot),
        .map_word (map_word),
        .hit_vec  (hit_vec)
    );

    qdma_evt_ctrl #(.NCH(NCH), .SLOT_W(SLOT_W)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_vec     (hit_vec),
        .hit_slot    (bus_addr[SLOT_SH +: SLOT_W]),
        .en_set_we   (en_set_we),
        .en_clr_we   (en_clr_we),
        .miss_clr_we (miss_clr_we),
        .sec_clr_we  (sec_clr_we),
        .wmask       (bus_wdata[NCH-1:0]),
        .done_valid  (done_valid),
        .done_chan   (done_chan),
        .en_q        (en_q),
        .sec_q       (sec_q),
        .miss_q      (miss_q),
        .req_valid   (req_valid),
        .req_slot    (req_slot)
    );

    qdma_pend #(.CODE_W(CODE_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_valid (done_valid),
        .done_code  (done_code),
        .clr_we     (pclr_we),
        .wdata      (bus_wdata),
        .pend_q     (pend_q)
    );

    // Read multiplexer; unmapped addresses and the slot window read zero.
    always_comb begin
        bus_rdata = '0;
        if (map_area) begin
            bus_rdata[MAP_SLOT_LSB +: SLOT_W] = map_slot[map_idx];
            bus_rdata[MAP_WORD_LSB +: WORD_W] = map_word[map_idx];
        end else if (bus_addr == AW'(EN_SET))    bus_rdata[NCH-1:0] = en_q;
        else if (bus_addr == AW'(SEC_STAT))      bus_rdata[NCH-1:0] = sec_q;
        else if (bus_addr == AW'(MISS_STAT))     bus_rdata[NCH-1:0] = miss_q;
        else if (bus_addr == AW'(PEND_LO))       bus_rdata = pend_q[0 +: 32];
        else if (bus_addr == AW'(PEND_HI))       bus_rdata = pend_q[32 +: 32];
    end
endmodule

// File: tb/tb_qdma_trig_mapper.sv
`timescale 1ns/1ps
module tb_qdma_trig_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        done_valid = 1'b0;
    logic [2:0]  done_chan = '0;
    logic [5:0]  done_code = '0;
    logic [7:0]  req_valid;
    logic [8:0]  req_slot;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    qdma_trig_mapper dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_valid(done_valid),
        .done_chan(done_chan), .done_code(done_code), .req_valid(req_valid),
        .req_slot(req_slot)
    );

    // Table fields: [23:21] channel, [20:12] slot, [11:9] mapped word,
    // [8:6] word written, [5:0] completion code.
    localparam logic [23:0] TBL [6] = '{
        {3'd0, 9'h000, 3'd0, 3'd0, 6'd0},
        {3'd3, 9'h1FF, 3'd7, 3'd7, 6'd33},
        {3'd7, 9'h0A5, 3'd2, 3'd5, 6'd12},
        {3'd5, 9'h100, 3'd4, 3'd4, 6'd31},
        {3'd1, 9'h002, 3'd6, 3'd6, 6'd63},
        {3'd2, 9'h055, 3'd1, 3'd0, 6'd7}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Two writes in consecutive cycles; returns after the second write edge.
    task automatic wr2(input logic [31:0] a1, input logic [31:0] d1,
                       input logic [31:0] a2, input logic [31:0] d2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'(a1); bus_wdata = d1;
        @(negedge clk);
        bus_addr = 16'(a2); bus_wdata = d2;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 16'(a);
        #1 d = bus_rdata;
    endtask

    task automatic done(input logic [2:0] ch, input logic [5:0] code);
        @(negedge clk);
        done_valid = 1'b1; done_chan = ch; done_code = code;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    function automatic logic [31:0] saddr(input logic [8:0] s, input logic [2:0] w);
        return 32'h4000 + 32'(s) * 32 + 32'(w) * 4;
    endfunction

    // Trigger write, then sample the request in the cycle it must appear.
    task automatic trig(input logic [31:0] a, output logic [7:0] rv,
                        output logic [8:0] rs);
        wr(a, 32'hA5A5_0000);
        @(negedge clk);
        rv = req_valid; rs = req_slot;
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  rv;
        logic [8:0]  rs;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(32'h0200, d); chk("R1", "map0", d, 0);
        rd(32'h021C, d); chk("R1", "map7", d, 0);
        rd(32'h108C, d); chk("R1", "enable", d, 0);
        rd(32'h1090, d); chk("R1", "outstanding", d, 0);
        rd(32'h0310, d); chk("R1", "missed", d, 0);
        rd(32'h1068, d); chk("R1", "pend lo", d, 0);
        rd(32'h106C, d); chk("R1", "pend hi", d, 0);
        chk("R1", "req_valid", 32'(req_valid), 0);

        // R2 R4 R5 R7 R8 table walk
        foreach (TBL[i]) begin
            logic [2:0]  ch;
            logic [8:0]  sl;
            logic [2:0]  mw, ww;
            logic [5:0]  cd;
            logic [31:0] elo, ehi;
            logic        hit;
            {ch, sl, mw, ww, cd} = TBL[i];
            hit = (mw == ww);
            wr(32'h0200 + 32'(ch) * 4, (32'(sl) << 5) | (32'(mw) << 2));
            rd(32'h0200 + 32'(ch) * 4, d);
            chk("R2", "map readback", d, (32'(sl) << 5) | (32'(mw) << 2));
            wr(32'h108C, 32'(1) << ch);
            trig(saddr(sl, ww), rv, rs);
            chk(hit ? "R4" : "R5", "req_valid", 32'(rv), hit ? (32'(1) << ch) : 0);
            if (hit) chk("R4", "req_slot", 32'(rs), 32'(sl));
            @(negedge clk);
            chk("R4", "pulse ends", 32'(req_valid), 0);
            rd(32'h1090, d);
            chk("R4", "outstanding", d, hit ? (32'(1) << ch) : 0);
            if (hit) begin
                elo = (cd < 32) ? (32'(1) << cd) : 0;
                ehi = (cd >= 32) ? (32'(1) << (cd - 32)) : 0;
                done(ch, cd);
                rd(32'h1068, d); chk("R7", "pend lo", d, elo);
                rd(32'h106C, d); chk("R7", "pend hi", d, ehi);
                rd(32'h1090, d); chk("R7", "outstanding cleared", d, 0);
                wr(32'h1070, elo);
                wr(32'h1074, ehi);
                rd(32'h1068, d); chk("R8", "pend lo cleared", d, 0);
                rd(32'h106C, d); chk("R8", "pend hi cleared", d, 0);
            end
            wr(32'h1088, 32'(1) << ch);
        end

        // R2 only the two fields are kept
        wr(32'h0210, 32'hFFFF_FFFF);
        rd(32'h0210, d); chk("R2", "map field mask", d, 32'h0000_3FFC);

        // R3 enable set/clear, zero bits ignored
        wr(32'h108C, 32'h06);
        wr(32'h108C, 32'h00);
        rd(32'h108C, d); chk("R3", "set with zero", d, 32'h06);
        wr(32'h1088, 32'h02);
        rd(32'h108C, d); chk("R3", "clear bit1", d, 32'h04);
        wr(32'h1088, 32'h00);
        rd(32'h108C, d); chk("R3", "clear with zero", d, 32'h04);
        wr(32'h1088, 32'h04);

        // R5 disabled channel
        wr(32'h0210, (32'd9 << 5) | (32'd3 << 2));
        trig(saddr(9'd9, 3'd3), rv, rs);
        chk("R5", "disabled no req", 32'(rv), 0);
        rd(32'h1090, d); chk("R5", "disabled no outstanding", d, 0);

        // R6 trigger while outstanding
        wr(32'h0218, (32'd20 << 5) | (32'd1 << 2));
        wr(32'h108C, 32'h40);
        trig(saddr(9'd20, 3'd1), rv, rs);
        chk("R4", "ch6 req", 32'(rv), 32'h40);
        trig(saddr(9'd20, 3'd1), rv, rs);
        chk("R6", "busy no req", 32'(rv), 0);
        rd(32'h0310, d); chk("R6", "missed set", d, 32'h40);

        // R9 write-one clears of missed and outstanding
        wr(32'h0314, 32'h40);
        rd(32'h0310, d); chk("R9", "missed cleared", d, 0);
        wr(32'h1094, 32'h40);
        rd(32'h1090, d); chk("R9", "outstanding cleared", d, 0);
        trig(saddr(9'd20, 3'd1), rv, rs);
        chk("R9", "req after clear", 32'(rv), 32'h40);
        wr(32'h1094, 32'h40);

        // R10 enable-clear overrides trigger
        wr2(saddr(9'd20, 3'd1), 32'h0, 32'h1088, 32'h40);
        chk("R10", "enclr no req", 32'(req_valid), 0);
        rd(32'h1090, d); chk("R10", "enclr no outstanding", d, 0);
        rd(32'h108C, d); chk("R10", "enclr disabled", d, 0);

        // R10 missed-clear overrides trigger on busy channel
        wr(32'h108C, 32'h40);
        trig(saddr(9'd20, 3'd1), rv, rs);
        chk("R4", "ch6 req again", 32'(rv), 32'h40);
        wr2(saddr(9'd20, 3'd1), 32'h0, 32'h0314, 32'h40);
        chk("R10", "missclr no req", 32'(req_valid), 0);
        rd(32'h0310, d); chk("R10", "missclr no missed", d, 0);
        rd(32'h1090, d); chk("R10", "outstanding kept", d, 32'h40);
        wr(32'h1094, 32'h40);
        wr(32'h1088, 32'h40);

        // R4 two channels on the same trigger word
        wr(32'h0200, (32'd7 << 5) | (32'd3 << 2));
        wr(32'h0204, (32'd7 << 5) | (32'd3 << 2));
        wr(32'h108C, 32'h03);
        trig(saddr(9'd7, 3'd3), rv, rs);
        chk("R4", "dual req", 32'(rv), 32'h03);
        chk("R4", "dual slot", 32'(rs), 32'd7);
        done(3'd0, 6'd1);
        done(3'd1, 6'd40);
        rd(32'h1068, d); chk("R7", "code1", d, 32'h2);
        rd(32'h106C, d); chk("R7", "code40", d, 32'h100);

        // R8 set beats clear in the same cycle
        @(negedge clk);
        done_valid = 1'b1; done_chan = 3'd0; done_code = 6'd1;
        bus_wr = 1'b1; bus_addr = 16'h1070; bus_wdata = 32'h2;
        @(negedge clk);
        done_valid = 1'b0; bus_wr = 1'b0;
        rd(32'h1068, d); chk("R8", "set wins", d, 32'h2);
        wr(32'h1070, 32'h2);
        wr(32'h1074, 32'h100);
        rd(32'h1068, d); chk("R8", "lo clear", d, 0);
        rd(32'h106C, d); chk("R8", "hi clear", d, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule